// File: doc/BRIEF.md
# Addressed Serial Register Port

This block is a framed serial slave that gives a host access to a converter's small register set. A frame starts when the active-low frame signal falls and ends when it rises. While the frame is open, the host shifts one 16-bit word in, MSB first, and the block shifts one 16-bit word out at the same time. The two top bits of the incoming word are a write address. That address picks the control register, a test register, one of four calibration coefficient registers, or nothing. The other 14 bits are the data.

The read path has no address in the frame. A two-bit read selector held in the control register picks the outgoing word, and it stays in force until the control register is rewritten. The block captures that word when the frame opens. Every control field appears on its own output pin. Two done pulses from the converter core clear the conversion-start and calibration-start bits. The interface-mode bit lasts for one frame only: every completed frame that does not write the control register clears it.

The serial pins are oversampled by the block clock through a synchronizer. The serial clock must therefore be slow relative to `clk`. The serial clock idles low.

Top module: `sreg_serial_port`

## Requirements
- R1: The frame word is 16 bits, shifted MSB first. Incoming bits are taken on rising serial-clock edges and outgoing bits change after falling edges. Each serial-clock phase must last at least SYNC_STAGES+2 `clk` cycles.
- R2: Registers change only once the 16th rising edge of an open frame has arrived. A frame that closes after 1 to 15 rising edges changes nothing. Rising edges after the 16th in the same frame are ignored.
- R3: Word bits 15:14 are the write address: 00 discards the data, 01 writes the test register, 10 writes a calibration register, and 11 writes the control register.
- R4: The control bits map to the outputs as follows. Bit 13 is sgl_diff. Bits 12:10 are chan_sel. Bits 9:8 are pwr_mode. Bits 7:6 are rd_sel. Bit 5 is if_mode. Bit 4 is conv_go. Bit 3 is cal_sys. Bits 2:1 are cal_sel. Bit 0 is cal_go.
- R5: After reset every control, test and calibration bit is 0, and sdo is 0.
- R6: The outgoing word is chosen by rd_sel when the frame opens. 00 returns four zero bits followed by the 12-bit conv_result. 01 returns two zero bits followed by the test register. 10 returns two zero bits followed by the selected calibration register. 11 returns stat_word.
- R7: A read selection stays in force for any number of later frames until the control register is rewritten.
- R8: A completed frame with an address other than 11 clears if_mode.
- R9: A conv_done pulse clears conv_go and a cal_done pulse clears cal_go. All other control bits are left as they are.
- R10: While cal_go is 0, cal_sel picks the calibration register that is written and read. While cal_go is 1, calibration writes are discarded and calibration reads return zero.
- R11: sdo is held at 0 whenever no frame is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, idles low |
| sync_n | input | 1 | Active-low frame signal |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host, 0 outside a frame |
| conv_result | input | RES_W | Latest conversion result |
| stat_word | input | 16 | Status word returned when rd_sel is 11 |
| conv_done | input | 1 | One-cycle pulse that clears conv_go |
| cal_done | input | 1 | One-cycle pulse that clears cal_go |
| sgl_diff | output | 1 | Input configuration bit |
| chan_sel | output | 3 | Channel selection |
| pwr_mode | output | 2 | Power management setting |
| rd_sel | output | 2 | Sticky read selector |
| if_mode | output | 1 | Interface mode bit, lasts one frame |
| conv_go | output | 1 | Conversion start request |
| cal_sys | output | 1 | Calibration kind |
| cal_sel | output | 2 | Calibration register / type selector |
| cal_go | output | 1 | Calibration start request |

## Verification
A wrong bit count or a misplaced write strobe shows on the control field pins within a few `clk` cycles after the 16th rising edge. An early strobe shows the same way when an aborted frame closes. A write that lands in the wrong register is hidden until a later frame reads that register back. That happens one or two frames later, depending on whether rd_sel has to be rewritten first. A stale or wrongly shifted transmit register corrupts the very next outgoing word bit by bit, so the bench compares every returned word against a model of all registers. A self-clearing bit that fails to clear is visible on its pin two cycles after the done pulse or the frame completion.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int WORD_W    = 16;
  localparam int ADDR_W    = 2;
  localparam int REG_W     = WORD_W - ADDR_W;
  localparam int CAL_SEL_W = 2;
  localparam int CAL_N     = 2 ** CAL_SEL_W;

  typedef enum logic [ADDR_W-1:0] {
    WA_NONE = 2'b00,
    WA_TEST = 2'b01,
    WA_CAL  = 2'b10,
    WA_CTRL = 2'b11
  } waddr_e;

  typedef enum logic [1:0] {
    RS_RESULT = 2'b00,
    RS_TEST   = 2'b01,
    RS_CAL    = 2'b10,
    RS_STATUS = 2'b11
  } rsel_e;

  // Field order, MSB first, defines the bit positions of the control word.
  typedef struct packed {
    logic                 sgl_diff;
    logic [2:0]           chan;
    logic [1:0]           pwr;
    rsel_e                rd_sel;
    logic                 if_mode;
    logic                 conv_go;
    logic                 cal_sys;
    logic [CAL_SEL_W-1:0] cal_sel;
    logic                 cal_go;
  } ctrl_t;

  function automatic logic [ADDR_W-1:0] word_addr(input logic [WORD_W-1:0] w);
    return w[WORD_W-1 -: ADDR_W];
  endfunction

  function automatic logic [REG_W-1:0] word_data(input logic [WORD_W-1:0] w);
    return w[REG_W-1:0];
  endfunction

  function automatic logic [WORD_W-1:0] widen_reg(input logic [REG_W-1:0] d);
    return {{ADDR_W{1'b0}}, d};
  endfunction
endpackage

// File: rtl/sreg_sampler.sv
module sreg_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  input  logic sync_n_in,
  input  logic sdi_in,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic frame_act,
  output logic frame_start,
  output logic frame_end,
  output logic sdi_s
);
  localparam int NSIG = 3;
  localparam logic [NSIG-1:0] IDLE = 3'b010;  // {sclk, sync_n, sdi}

  logic [NSIG-1:0] chain [STAGES];
  logic            sclk_d;
  logic            act_d;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= IDLE;
          else        chain[g] <= {sclk_in, sync_n_in, sdi_in};
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= IDLE;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  logic [NSIG-1:0] synced;
  assign synced    = chain[STAGES-1];
  assign frame_act = ~synced[1];
  assign sdi_s     = synced[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      act_d  <= 1'b0;
    end else begin
      sclk_d <= synced[2];
      act_d  <= frame_act;
    end
  end

  assign sclk_rise   = synced[2] & ~sclk_d;
  assign sclk_fall   = ~synced[2] & sclk_d;
  assign frame_start = frame_act & ~act_d;
  assign frame_end   = ~frame_act & act_d;
endmodule

// File: rtl/sreg_frame.sv
module sreg_frame #(
  parameter int W = 16,
  localparam int CNT_W = $clog2(W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_rise,
  input  logic             sclk_fall,
  input  logic             frame_act,
  input  logic             frame_start,
  input  logic             frame_end,
  input  logic             sdi_s,
  input  logic [W-1:0]     load_word,
  output logic [W-1:0]     rx_word,
  output logic             frame_done,
  output logic             frame_abort,
  output logic [CNT_W-1:0] bit_cnt,
  output logic             sdo
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [W-1:0]     rx_q;
  logic [W-1:0]     tx_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             abort_q;
  logic             take;
  logic             shift_out;

  assign take      = frame_act & sclk_rise & ~frame_start & (cnt_q < FULL);
  assign shift_out = frame_act & sclk_fall & ~frame_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q    <= '0;
      tx_q    <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      done_q  <= take && (cnt_q == LAST);
      abort_q <= frame_end && (cnt_q != '0) && (cnt_q < FULL);
      if (frame_start) begin
        cnt_q <= '0;
        tx_q  <= load_word;
      end else begin
        if (take) begin
          rx_q  <= {rx_q[W-2:0], sdi_s};
          cnt_q <= cnt_q + 1'b1;
        end
        if (shift_out) tx_q <= {tx_q[W-2:0], 1'b0};
      end
    end
  end

  assign rx_word     = rx_q;
  assign frame_done  = done_q;
  assign frame_abort = abort_q;
  assign bit_cnt     = cnt_q;
  assign sdo         = frame_act & tx_q[W-1];
endmodule

// File: rtl/sreg_regs.sv
module sreg_regs
  import sreg_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              conv_done,
  input  logic              cal_done,
  input  logic [RES_W-1:0]  conv_result,
  input  logic [WORD_W-1:0] stat_word,
  output ctrl_t             ctrl,
  output logic [WORD_W-1:0] read_word
);
  ctrl_t            ctrl_q;
  logic [REG_W-1:0] test_q;
  logic [REG_W-1:0] cal_q [CAL_N];
  waddr_e           wr_addr;
  logic [REG_W-1:0] wr_data;
  logic             wr_ctrl;
  logic             wr_test;
  logic             wr_cal;

  function automatic logic [WORD_W-1:0] pad_result(input logic [RES_W-1:0] r);
    return {{(WORD_W - RES_W){1'b0}}, r};
  endfunction

  assign wr_addr = waddr_e'(word_addr(rx_word));
  assign wr_data = word_data(rx_word);
  assign wr_ctrl = frame_done && (wr_addr == WA_CTRL);
  assign wr_test = frame_done && (wr_addr == WA_TEST);
  assign wr_cal  = frame_done && (wr_addr == WA_CAL) && !ctrl_q.cal_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= ctrl_t'(wr_data);
    end else begin
      if (frame_done) ctrl_q.if_mode <= 1'b0;
      if (conv_done)  ctrl_q.conv_go <= 1'b0;
      if (cal_done)   ctrl_q.cal_go  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       test_q <= '0;
    else if (wr_test) test_q <= wr_data;
  end

  genvar g;
  generate
    for (g = 0; g < CAL_N; g++) begin : g_cal
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cal_q[g] <= '0;
        else if (wr_cal && (ctrl_q.cal_sel == CAL_SEL_W'(g))) cal_q[g] <= wr_data;
      end
    end
  endgenerate

  always_comb begin
    unique case (ctrl_q.rd_sel)
      RS_RESULT: read_word = pad_result(conv_result);
      RS_TEST:   read_word = widen_reg(test_q);
      RS_CAL:    read_word = ctrl_q.cal_go ? '0 : widen_reg(cal_q[ctrl_q.cal_sel]);
      default:   read_word = stat_word;
    endcase
  end

  assign ctrl = ctrl_q;
endmodule

// File: rtl/sreg_serial_port.sv
module sreg_serial_port
  import sreg_pkg::*;
#(
  parameter int RES_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sync_n,
  input  logic              sdi,
  output logic              sdo,
  input  logic [RES_W-1:0]  conv_result,
  input  logic [WORD_W-1:0] stat_word,
  input  logic              conv_done,
  input  logic              cal_done,
  output logic              sgl_diff,
  output logic [2:0]        chan_sel,
  output logic [1:0]        pwr_mode,
  output logic [1:0]        rd_sel,
  output logic              if_mode,
  output logic              conv_go,
  output logic              cal_sys,
  output logic [1:0]        cal_sel,
  output logic              cal_go
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  // Named internal events, observed by the bound checker.
  logic              sclk_rise;
  logic              sclk_fall;
  logic              frame_act;
  logic              frame_start;
  logic              frame_end;
  logic              sdi_s;
  logic              frame_done;
  logic              frame_abort;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] rx_word;
  logic [WORD_W-1:0] read_word;
  logic [ADDR_W-1:0] rx_addr;
  logic [REG_W-1:0]  ctrl_bits;
  ctrl_t             ctrl_q;

  sreg_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk_in     (sclk),
    .sync_n_in   (sync_n),
    .sdi_in      (sdi),
    .sclk_rise   (sclk_rise),
    .sclk_fall   (sclk_fall),
    .frame_act   (frame_act),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .sdi_s       (sdi_s)
  );

  sreg_frame #(.W(WORD_W)) u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk_rise   (sclk_rise),
    .sclk_fall   (sclk_fall),
    .frame_act   (frame_act),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .sdi_s       (sdi_s),
    .load_word   (read_word),
    .rx_word     (rx_word),
    .frame_done  (frame_done),
    .frame_abort (frame_abort),
    .bit_cnt     (bit_cnt),
    .sdo         (sdo)
  );

  sreg_regs #(.RES_W(RES_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_done  (frame_done),
    .rx_word     (rx_word),
    .conv_done   (conv_done),
    .cal_done    (cal_done),
    .conv_result (conv_result),
    .stat_word   (stat_word),
    .ctrl        (ctrl_q),
    .read_word   (read_word)
  );

  assign rx_addr   = word_addr(rx_word);
  assign ctrl_bits = ctrl_q;

  assign sgl_diff = ctrl_q.sgl_diff;
  assign chan_sel = ctrl_q.chan;
  assign pwr_mode = ctrl_q.pwr;
  assign rd_sel   = ctrl_q.rd_sel;
  assign if_mode  = ctrl_q.if_mode;
  assign conv_go  = ctrl_q.conv_go;
  assign cal_sys  = ctrl_q.cal_sys;
  assign cal_sel  = ctrl_q.cal_sel;
  assign cal_go   = ctrl_q.cal_go;
endmodule

// File: rtl/sreg_serial_port_chk.sv
module sreg_serial_port_chk #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 5,
  parameter int REG_W  = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sdo,
  input logic             frame_act,
  input logic             frame_done,
  input logic             frame_abort,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             conv_done,
  input logic             cal_done,
  input logic [REG_W-1:0] ctrl_bits,
  input logic [1:0]       rx_addr
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  assert_sdo_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_act |-> (sdo == 1'b0));

  assert_bit_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= FULL);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_done && !conv_done && !cal_done) |=> $stable(ctrl_bits));

  assert_abort_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frame_done, frame_abort}));

  assert_reset_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ctrl_bits == '0));

  assert_mode_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && rx_addr != 2'b11) |=> !ctrl_bits[5]);

  assert_conv_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !frame_done) |=> !ctrl_bits[4]);

  assert_cal_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_done && !frame_done) |=> !ctrl_bits[0]);
endmodule

bind sreg_serial_port sreg_serial_port_chk #(
  .WORD_W (sreg_pkg::WORD_W),
  .CNT_W  ($clog2(sreg_pkg::WORD_W + 1)),
  .REG_W  (sreg_pkg::REG_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sdo         (sdo),
  .frame_act   (frame_act),
  .frame_done  (frame_done),
  .frame_abort (frame_abort),
  .bit_cnt     (bit_cnt),
  .conv_done   (conv_done),
  .cal_done    (cal_done),
  .ctrl_bits   (ctrl_bits),
  .rx_addr     (rx_addr)
);

// File: tb/sreg_serial_port_test.sv
module sreg_serial_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int RES_W      = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sclk = 1'b0;
  logic             sync_n = 1'b1;
  logic             sdi = 1'b0;
  logic             conv_done = 1'b0;
  logic             cal_done = 1'b0;
  logic [RES_W-1:0] conv_result = '0;
  logic [15:0]      stat_word = '0;
  logic             sdo, sgl_diff, if_mode, conv_go, cal_sys, cal_go;
  logic [2:0]       chan_sel;
  logic [1:0]       pwr_mode, rd_sel, cal_sel;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [13:0] m_ctrl;
  logic [13:0] m_test;
  logic [13:0] m_cal [4];

  always #(CLK_PERIOD / 2) clk = ~clk;

  sreg_serial_port #(.RES_W(RES_W), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n), .sdi(sdi), .sdo(sdo),
    .conv_result(conv_result), .stat_word(stat_word),
    .conv_done(conv_done), .cal_done(cal_done),
    .sgl_diff(sgl_diff), .chan_sel(chan_sel), .pwr_mode(pwr_mode), .rd_sel(rd_sel),
    .if_mode(if_mode), .conv_go(conv_go), .cal_sys(cal_sys), .cal_sel(cal_sel),
    .cal_go(cal_go)
  );

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [13:0] port_ctrl();
    return {sgl_diff, chan_sel, pwr_mode, rd_sel, if_mode, conv_go, cal_sys, cal_sel, cal_go};
  endfunction

  function automatic logic [15:0] exp_read();
    case (m_ctrl[7:6])
      2'b00:   return {4'b0000, conv_result};
      2'b01:   return {2'b00, m_test};
      2'b10:   return m_ctrl[0] ? 16'h0000 : {2'b00, m_cal[m_ctrl[2:1]]};
      default: return stat_word;
    endcase
  endfunction

  task automatic xfer(input logic [15:0] tx, input int nbits, output logic [15:0] rx);
    rx = '0;
    sync_n = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 16) ? tx[15-i] : 1'b1;
      wait_clks(HALF);
      if (i < 16) rx[15-i] = sdo;
      sclk = 1'b1;
      wait_clks(HALF);
      sclk = 1'b0;
    end
    wait_clks(HALF);
    sync_n = 1'b1;
    sdi = 1'b0;
    wait_clks(2 * HALF);
  endtask

  // Full frame: checks the returned word, updates the model, checks the pins.
  task automatic frame(input logic [15:0] tx, input string req);
    logic [15:0] rx;
    logic [15:0] exp;
    exp = exp_read();
    xfer(tx, 16, rx);
    check(req, rx, exp);
    case (tx[15:14])
      2'b01:   m_test = tx[13:0];
      2'b10:   if (!m_ctrl[0]) m_cal[m_ctrl[2:1]] = tx[13:0];
      2'b11:   m_ctrl = tx[13:0];
      default: ;
    endcase
    if (tx[15:14] != 2'b11) m_ctrl[5] = 1'b0;
    check("R3 pins", {2'b00, port_ctrl()}, {2'b00, m_ctrl});
    check("R11 idle", {15'd0, sdo}, 16'h0000);
  endtask

  task automatic pulse(input bit which_cal);
    if (which_cal) cal_done = 1'b1; else conv_done = 1'b1;
    wait_clks(1);
    cal_done = 1'b0;
    conv_done = 1'b0;
    wait_clks(2);
    if (which_cal) m_ctrl[0] = 1'b0; else m_ctrl[4] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rx;
    m_ctrl = '0;
    m_test = '0;
    for (int k = 0; k < 4; k++) m_cal[k] = '0;
    wait_clks(5);
    rst_n = 1'b1;
    wait_clks(3);

    // R5: reset state
    check("R5 ctrl", {2'b00, port_ctrl()}, 16'h0000);
    check("R5 sdo", {15'd0, sdo}, 16'h0000);

    // R6: default read of result with four leading zeros; R3: address 00 discards
    conv_result = 12'hA5C;
    frame(16'h3FFF, "R6 result");
    check("R3 discard", {2'b00, port_ctrl()}, 16'h0000);

    // R4: walking one across the control word
    for (int b = 0; b < 14; b++) begin
      frame({2'b11, 14'(1 << b)}, "R6 walk");
      check("R4 walk", {2'b00, port_ctrl()}, {2'b00, 14'(1 << b)});
    end
    frame({2'b11, 14'b1_101_10_00_0_0_1_11_0}, "R1 field");
    check("R4 chan", {13'd0, chan_sel}, 16'h0005);
    check("R4 pwr", {14'd0, pwr_mode}, 16'h0002);
    check("R4 calsel", {14'd0, cal_sel}, 16'h0003);
    check("R4 sgl", {14'd0, sgl_diff, cal_sys}, 16'h0003);

    // R7: test register sweep with a sticky read selection
    frame({2'b11, 14'h0040}, "R6 sel");
    for (int k = 0; k < 8; k++) begin
      logic [13:0] v;
      v = 14'((k * 2113) ^ (k << 10)) | ((k == 7) ? 14'h3FFF : 14'h0);
      frame({2'b01, v}, "R7 write");
      frame({2'b00, ~v}, "R7 read");
      frame(16'h0000, "R7 reread");
    end

    // R10: calibration bank, each entry written then read back
    for (int k = 0; k < 4; k++) begin
      frame({2'b11, 8'h02, 3'b000, 2'(k), 1'b0}, "R10 sel");
      frame({2'b10, 14'(16'h1111 * (k + 1) + 16'h0203 * k)}, "R10 write");
    end
    for (int k = 3; k >= 0; k--) begin
      frame({2'b11, 8'h02, 3'b000, 2'(k), 1'b0}, "R10 sel");
      frame(16'h0000, "R10 read");
    end
    // R10: while cal_go is set, writes dropped and reads return zero
    frame({2'b11, 14'h0083}, "R10 busy");
    frame({2'b10, 14'h1234}, "R10 busy write");
    frame(16'h0000, "R10 busy read");
    pulse(1'b1);
    check("R9 cal clear", {2'b00, port_ctrl()}, {2'b00, m_ctrl});
    frame(16'h0000, "R10 after");

    // R6: status sweep and result sweep
    frame({2'b11, 14'h00C0}, "R6 sel");
    for (int k = 0; k < 6; k++) begin
      stat_word = 16'(k * 16'h3C5B + 1);
      frame(16'h0000, "R6 status");
    end
    frame({2'b11, 14'h0000}, "R6 sel");
    for (int k = 0; k < 6; k++) begin
      conv_result = 12'(k * 12'h2B7 + 12'hFFF * (k == 5 ? 1 : 0));
      frame(16'h0000, "R6 result");
    end

    // R8: interface mode lasts one frame
    frame({2'b11, 14'h0020}, "R8 set");
    check("R8 set", {15'd0, if_mode}, 16'h0001);
    frame(16'h0000, "R8 read");
    check("R8 clear", {15'd0, if_mode}, 16'h0000);
    frame({2'b11, 14'h0020}, "R8 set");
    frame({2'b01, 14'h0155}, "R8 test");
    check("R8 clear test", {15'd0, if_mode}, 16'h0000);

    // R9: conversion start cleared by done pulse, other bits kept
    frame({2'b11, 14'h2010}, "R9 set");
    check("R9 set", {15'd0, conv_go}, 16'h0001);
    pulse(1'b0);
    check("R9 conv clear", {2'b00, port_ctrl()}, 16'h2000);

    // R2: aborted frames change nothing
    for (int n = 1; n < 16; n++) begin
      xfer({2'b11, ~m_ctrl}, n, rx);
      check("R2 abort", {2'b00, port_ctrl()}, {2'b00, m_ctrl});
    end
    frame(16'h0000, "R2 after abort");
    // R2: clocks past the 16th are ignored
    xfer({2'b11, 14'h0123}, 20, rx);
    m_ctrl = 14'h0123;
    check("R2 extra", {2'b00, port_ctrl()}, {2'b00, m_ctrl});
    check("R11 idle end", {15'd0, sdo}, 16'h0000);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule